// File: doc/BRIEF.md
# Watchdog and Clock Supervisor

This block watches over a processor's clock domain in two ways and reports any fault on a single active-low error line. A service-window watchdog expects software to pulse a service strobe inside a window: neither too soon after the last restart nor too late. A clock monitor counts system clock cycles between pulses of a slow reference tick. If too few cycles fit between two ticks, the system clock is judged too slow.

Both checkers start armed when reset is released. The watchdog starts with its largest window. The clock monitor starts in the error state and stays there until it measures an acceptable clock. Either fault turns on the error pin's output enable and drives the pin low. When no fault is present the pin is left floating (high-impedance). Software may write the window select once after reset; later writes are ignored.

Top module: `wdcm_supervisor`

## Requirements
- R1: While `rst_n` is low, `err_oe` is 0 and `err_drive_n` is 1, whatever the other inputs do.
- R2: After reset the window select is 3, the largest window, and the select is unlocked. The clock monitor starts in the error state, so `err_oe` is 1 from the first clock edge after reset is released until the monitor recovers (R4).
- R3: A tick is a slow measurement when its gap is fewer than `CM_MIN` cycles. The gap is the number of clock edges from the previous `ref_tick` (or from reset release) to this one. A slow measurement sets the clock-monitor error on that same edge and cancels any recovery in progress.
- R4: A tick is a good measurement when its gap is at least `CM_MIN` cycles. A good measurement seen while the monitor is in error, with no recovery running, clears the error exactly `CM_HOLD` edges later; `CM_HOLD` lies between 16 and 32. Good ticks have no effect while the monitor is clean or already recovering.
- R5: Each select value sel gives a window of upper = 2^(`WIN_LOG_MAX` − 2·(3 − sel)) cycles. If no strobe comes, the watchdog expires on the upper-th edge after its last restart, and that expiry also restarts the window.
- R6: Number the edges after a restart k = 1, 2, …, and let lower = upper/4. A strobe on edge k ≤ lower is early and raises a watchdog error. A strobe on an edge with lower < k ≤ upper is valid and raises no error. Any strobe restarts the window on its edge.
- R7: A watchdog error, whether early or expired, holds `err_oe` high for exactly `WD_HOLD` edges. The count starts again if a new watchdog error occurs meanwhile.
- R8: The first `win_wr` after reset loads `win_sel_in` and locks the select. Every later `win_wr` is ignored until the next reset.
- R9: `err_oe` is the OR of the watchdog and clock-monitor errors. `err_drive_n` is always the inverse of `err_oe`, so the pin is only ever driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse of the slow reference, synchronous to clk |
| svc_strobe | input | 1 | Watchdog service pulse |
| win_wr | input | 1 | Write strobe for the window select |
| win_sel_in | input | 2 | Window select value (3 = largest) |
| err_drive_n | output | 1 | Pin drive value, low while an error is present |
| err_oe | output | 1 | Pin output enable, high while an error is present |

## Verification
On every cycle the assertions check the following. A strobe restarts the window counter. A locked select never changes. Once the select has been stable for a cycle, the counter stays below the window bound. A slow tick always leaves the monitor in error, and the monitor only clears from a running recovery. A watchdog error always reaches the pin on the next cycle. Only the bench scenarios can show the exact timing: the window length set by each select value, the early/valid boundary at lower and lower+1, a strobe accepted on the very last edge, the 16-edge hold, the recovery delay after a good tick, a recovery cancelled by a slow tick, and a second window write having no effect.

// File: rtl/wdcm_pkg.sv
package wdcm_pkg;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned SEL_MAX = 3;

  // Window length in cycles for a select value; each step down divides by 4.
  function automatic int unsigned win_upper(input int unsigned sel, input int unsigned log_max);
    return 32'd1 << (log_max - 2 * (SEL_MAX - sel));
  endfunction

  // Earliest legal service point: strobes at or before this edge are early.
  function automatic int unsigned win_lower(input int unsigned sel, input int unsigned log_max);
    return win_upper(sel, log_max) >> 2;
  endfunction

  // gap_m1 is the gap counter value, one less than the edge distance between ticks.
  function automatic logic gap_ok(input int unsigned gap_m1, input int unsigned min_cyc);
    return (gap_m1 + 1) >= min_cyc;
  endfunction
endpackage

// File: rtl/wdcm_window.sv
module wdcm_window
  import wdcm_pkg::*;
#(
  parameter int unsigned WIN_LOG_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_i,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             early_o,
  output logic             expire_o
);
  localparam int unsigned CNT_W = WIN_LOG_MAX + 1;

  logic [SEL_W-1:0] sel_q;
  logic             locked_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] upper;
  logic [CNT_W-1:0] lower;
  logic             restart;

  assign upper    = CNT_W'(win_upper(32'(sel_q), WIN_LOG_MAX));
  assign lower    = CNT_W'(win_lower(32'(sel_q), WIN_LOG_MAX));
  assign early_o  = svc_i && (cnt_q < lower);
  assign expire_o = !svc_i && (cnt_q >= upper - 1'b1);
  assign restart  = svc_i || expire_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SEL_W'(SEL_MAX);
      locked_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (wr_i && !locked_q) begin
        sel_q    <= sel_i;
        locked_q <= 1'b1;
      end
      cnt_q <= restart ? '0 : cnt_q + 1'b1;
    end
  end

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_i |=> (cnt_q == '0));

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(sel_q));

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && $past(locked_q)) || !locked_q |-> (cnt_q < upper));
endmodule

// File: rtl/wdcm_hold.sv
module wdcm_hold #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  output logic active_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (ev_i)            left_q <= HW'(HOLD);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign active_o = (left_q != '0);

  assert_hold_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i |=> active_o);
endmodule

// File: rtl/wdcm_clkmon.sv
module wdcm_clkmon
  import wdcm_pkg::*;
#(
  parameter int unsigned CM_MIN  = 8,
  parameter int unsigned CM_HOLD = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic bad_o
);
  localparam int unsigned PW = $clog2(CM_MIN + 1);
  localparam int unsigned RW = $clog2(CM_HOLD + 1);
  localparam logic [PW-1:0] GAP_SAT = PW'(CM_MIN - 1);
  localparam logic [RW-1:0] REC_END = RW'(CM_HOLD - 1);

  logic [PW-1:0] gap_q;
  logic [RW-1:0] rc_q;
  logic          run_q;
  logic          bad_q;
  logic          meas_good;
  logic          meas_slow;

  assign meas_good = tick_i && gap_ok(32'(gap_q), CM_MIN);
  assign meas_slow = tick_i && !gap_ok(32'(gap_q), CM_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      rc_q  <= '0;
      run_q <= 1'b0;
      bad_q <= 1'b1;
    end else begin
      if (tick_i)                gap_q <= '0;
      else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;

      if (meas_slow) begin
        bad_q <= 1'b1;
        run_q <= 1'b0;
      end else if (run_q) begin
        if (rc_q == REC_END) begin
          bad_q <= 1'b0;
          run_q <= 1'b0;
        end else begin
          rc_q <= rc_q + 1'b1;
        end
      end else if (meas_good && bad_q) begin
        run_q <= 1'b1;
        rc_q  <= '0;
      end
    end
  end

  assign bad_o = bad_q;

  assert_slow_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_slow |=> bad_q);

  assert_release_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bad_q) |-> $past(run_q));
endmodule

// File: rtl/wdcm_supervisor.sv
module wdcm_supervisor
  import wdcm_pkg::*;
#(
  parameter int unsigned WIN_LOG_MAX = 16,
  parameter int unsigned WD_HOLD     = 16,
  parameter int unsigned CM_MIN      = 8,
  parameter int unsigned CM_HOLD     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             svc_strobe,
  input  logic             win_wr,
  input  logic [SEL_W-1:0] win_sel_in,
  output logic             err_drive_n,
  output logic             err_oe
);
  logic wd_early;
  logic wd_expire;
  logic wd_event;
  logic wd_active;
  logic cm_bad;

  wdcm_window #(.WIN_LOG_MAX(WIN_LOG_MAX)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_i    (svc_strobe),
    .wr_i     (win_wr),
    .sel_i    (win_sel_in),
    .early_o  (wd_early),
    .expire_o (wd_expire)
  );

  assign wd_event = wd_early || wd_expire;

  wdcm_hold #(.HOLD(WD_HOLD)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (wd_event),
    .active_o (wd_active)
  );

  wdcm_clkmon #(.CM_MIN(CM_MIN), .CM_HOLD(CM_HOLD)) u_clkmon (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (ref_tick),
    .bad_o  (cm_bad)
  );

  // Inhibit while reset is held; otherwise either fault pulls the pin low.
  assign err_oe      = rst_n && (wd_active || cm_bad);
  assign err_drive_n = !err_oe;

  assert_wd_reaches_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_event |=> err_oe);
endmodule

// File: tb/wdcm_supervisor_bench.sv
`timescale 1ns/1ps
module wdcm_supervisor_bench;
  localparam int unsigned LOGM  = 10;
  localparam int unsigned WHOLD = 16;
  localparam int unsigned CMIN  = 8;
  localparam int unsigned CHOLD = 24;
  localparam int LAST_EDGE = 400;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_tick, svc_strobe, win_wr;
  logic [1:0] win_sel_in;
  logic       err_drive_n, err_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic  exp_oe;
    string tag;
    int    edge_no;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  wdcm_supervisor #(.WIN_LOG_MAX(LOGM), .WD_HOLD(WHOLD), .CM_MIN(CMIN), .CM_HOLD(CHOLD))
    u_wdcm_supervisor (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .svc_strobe(svc_strobe),
      .win_wr(win_wr), .win_sel_in(win_sel_in),
      .err_drive_n(err_drive_n), .err_oe(err_oe));

  // Window with select 1: 64 cycles, early limit 16 (R5, R6).
  function automatic int wsize(input int sel);
    return 1 << (LOGM - 2 * (3 - sel));
  endfunction

  function automatic bit in_rng(input int e, input int lo, input int hi);
    return (e >= lo) && (e <= hi);
  endfunction

  // Expected pin state after edge e, from the scenario's error intervals.
  function automatic logic expect_oe(input int e);
    int w;
    w = wsize(1);
    return in_rng(e, 1, 33 + CHOLD - 1)                     // monitor armed, recovers from tick at 33
        || in_rng(e, 60 + w, 60 + w + WHOLD - 1)              // expiry after service at 60
        || in_rng(e, 166, 166 + WHOLD - 1)                    // early strobe
        || in_rng(e, 247 + w, 247 + w + WHOLD - 1)            // expiry after last-edge service
        || in_rng(e, 333, 343 + CHOLD - 1)                    // slow tick, then recovery
        || in_rng(e, 311 + w, 311 + w + WHOLD - 1);           // periodic expiry
  endfunction

  function automatic string tag_of(input int e);
    if (e <= 33)  return "R2 R3";
    if (e <= 57)  return "R4";
    if (e <= 123) return "R8 R6";
    if (e <= 140) return "R5 R7 R8";
    if (e <= 182) return "R6 R7";
    if (e <= 310) return "R6";
    if (e <= 327) return "R5 R7";
    if (e <= 332) return "R4";
    if (e <= 374) return "R3 R4";
    return "R5 R7";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Driver: one call per clock edge, pushes the expected pin state for that edge.
  task automatic drive_edge(input int e);
    svc_strobe = (e == 60) || (e == 150) || (e == 166) || (e == 183) || (e == 247);
    ref_tick   = (e == 3) || (e == 10) || (e == 20) || (e == 25) || (e == 33)
              || (e == 330) || (e == 333) || (e == 343);
    win_wr     = (e == 58) || (e == 61);
    win_sel_in = (e == 58) ? 2'd1 : 2'd3;
    sb.push_back('{exp_oe: expect_oe(e), tag: tag_of(e), edge_no: e});
  endtask

  // Monitor: samples just after each edge and compares against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (rst_n === 1'b1 && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(err_oe === it.exp_oe, it.tag, int'(err_oe), int'(it.exp_oe));
      check(err_drive_n === !err_oe, "R9", int'(err_drive_n), int'(!err_oe));
    end
  end

  initial begin
    rst_n = 1'b0;
    svc_strobe = 1'b0; ref_tick = 1'b0; win_wr = 1'b0; win_sel_in = 2'd0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      svc_strobe = i[0]; ref_tick = ~i[0]; win_wr = 1'b1;
      #1;
      check(err_oe === 1'b0, "R1", int'(err_oe), 0);
      check(err_drive_n === 1'b1, "R1", int'(err_drive_n), 1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    drive_edge(1);
    for (int e = 2; e <= LAST_EDGE; e++) begin
      @(negedge clk);
      drive_edge(e);
    end
    @(negedge clk);
    svc_strobe = 1'b0; ref_tick = 1'b0; win_wr = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule